// File: doc/BRIEF.md
# Triangle-Wave Frequency Dither Generator

This block spreads the spectrum of a programmable clock. It takes the frequency control word that sets an oscillator and produces a slowly varying copy of it. The copy is reduced by a digital triangle-wave offset, so the oscillator sweeps down from its programmed frequency and back, and never rises above it. The triangle is stepped from the master clock through a programmable divider. A 2-bit rate select picks one full sweep every 8192, 4096 or 2048 master-clock cycles. A 3-bit magnitude select picks the peak depth of the sweep as a power-of-two fraction of the control word.

The block sits between the frequency configuration and the oscillator's control input. While the dither enable is low, the control word passes through unchanged and the triangle is held at zero. The next enable therefore starts a new sweep from the undithered frequency. Some magnitude encodings are unassigned. Selecting one of them gives no dither and raises a flag.

Top module: `dither_gen`

## Requirements
- R1: With rate select 2'b00, the triangle advances one step every 64 master clocks and one full up-down sweep (128 steps) lasts 8192 master clocks.
- R2: With rate select 2'b01, the triangle advances one step every 32 master clocks, giving a 4096-clock sweep.
- R3: Rate selects 2'b10 and 2'b11 both step the triangle every 16 master clocks, giving a 2048-clock sweep.
- R4: The magnitude select sets the peak offset to the control word shifted right by 8, 7, 6, 5 or 4 bits for codes 3'b000, 3'b001, 3'b010, 3'b100 and 3'b111 respectively. At triangle value t (0 to 64) the offset is (word*t) >> (14 - k), where k is 0 to 4 in the same code order.
- R5: Magnitude codes 3'b011, 3'b101 and 3'b110 are reserved. They give an offset of zero, and the reserved flag is high one cycle after such a code is presented. The flag is low for the five valid codes, whatever the enable does.
- R6: The output word is never greater than the control word that was presented one cycle earlier.
- R7: While the enable is low, the output word equals the control word from the previous cycle.
- R8: The triangle value starts at 0, rises by one per step to 64, then falls by one per step to 0 and repeats. The output is registered: the output after clock edge j of an enabled run reflects the triangle value reached after edge j-1, which is 0 for the first edge of the run.
- R9: Dropping the enable for a cycle returns the triangle and divider to zero, so a re-enabled run restarts from zero offset at the start of a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dith_en | input | 1 | Dither enable, high to sweep |
| rate_sel | input | 2 | Sweep rate select |
| mag_sel | input | 3 | Sweep depth select |
| freq_word | input | WORD_W | Programmed frequency control word |
| out_word | output | WORD_W | Dithered frequency control word |
| rsv_flag | output | 1 | Reserved magnitude code presented |

## Verification
Every output is one register stage from its inputs. The pass-through value, the reserved flag and the dithered word are all due on the edge after the stimulus. The dithered word reflects the triangle value one step behind the divider. The bench drives inputs on the falling edge and counts rising edges from the first enabled edge. It compares the output half a period after each edge with a value built from the triangle position floor(j / step length), folded about 64. Each run is preceded by one disabled cycle, which checks the pass-through and restarts the sweep, so the cycle count needs no knowledge of the design's internal counters.

// File: rtl/dither_pkg.sv
package dither_pkg;

  typedef struct packed {
    logic       valid;
    logic [2:0] level;
  } mag_dec_t;

  function automatic mag_dec_t decode_mag(input logic [2:0] code);
    mag_dec_t d;
    d.valid = 1'b1;
    unique case (code)
      3'b000:  d.level = 3'd0;
      3'b001:  d.level = 3'd1;
      3'b010:  d.level = 3'd2;
      3'b100:  d.level = 3'd3;
      3'b111:  d.level = 3'd4;
      default: begin
        d.valid = 1'b0;
        d.level = 3'd0;
      end
    endcase
    return d;
  endfunction

  function automatic logic [1:0] rate_extra(input logic [1:0] code);
    logic [1:0] e;
    unique case (code)
      2'b00:   e = 2'd2;
      2'b01:   e = 2'd1;
      default: e = 2'd0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/dither_rate_div.sv
module dither_rate_div #(
  parameter int BASE_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  import dither_pkg::*;

  localparam int CW = BASE_LOG2 + 3;

  logic [CW-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = (CW'(1) << (BASE_LOG2 + int'(rate_extra(rate_sel)))) - CW'(1);
    tick  = run && (cnt_q == limit);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/dither_tri_cnt.sv
module dither_tri_cnt #(
  parameter int TRI_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  output logic [TRI_BITS:0] tri_val
);
  localparam logic [TRI_BITS:0] PEAK = (TRI_BITS+1)'(1) << TRI_BITS;
  localparam logic [TRI_BITS:0] ONE  = (TRI_BITS+1)'(1);

  logic [TRI_BITS:0] tri_q, tri_d;
  logic              down_q, down_d;

  always_comb begin
    tri_d  = tri_q;
    down_d = down_q;
    if (!run) begin
      tri_d  = '0;
      down_d = 1'b0;
    end else if (tick) begin
      if (!down_q) begin
        tri_d = tri_q + ONE;
        if (tri_q + ONE == PEAK) down_d = 1'b1;
      end else begin
        tri_d = tri_q - ONE;
        if (tri_q == ONE) down_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tri_q  <= '0;
      down_q <= 1'b0;
    end else begin
      tri_q  <= tri_d;
      down_q <= down_d;
    end
  end

  assign tri_val = tri_q;

endmodule

// File: rtl/dither_scaler.sv
module dither_scaler #(
  parameter int WORD_W    = 16,
  parameter int TRI_BITS  = 6,
  parameter int FRAC_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [2:0]        mag_sel,
  input  logic [WORD_W-1:0] word_in,
  input  logic [TRI_BITS:0] tri_val,
  output logic [WORD_W-1:0] word_out,
  output logic              rsv
);
  import dither_pkg::*;

  localparam int PW     = WORD_W + TRI_BITS + 1;
  localparam int LEVELS = 5;

  logic [PW-1:0]     prod;
  logic [WORD_W-1:0] cand [LEVELS];
  logic [WORD_W-1:0] offs;
  logic [WORD_W-1:0] word_d;
  logic              rsv_d;
  logic [WORD_W-1:0] word_q;
  logic              rsv_q;
  mag_dec_t          md;

  assign prod = PW'(word_in) * PW'(tri_val);

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    localparam int SH = TRI_BITS + FRAC_LOG2 - g;
    assign cand[g] = WORD_W'(prod >> SH);
  end

  always_comb begin
    md   = decode_mag(mag_sel);
    offs = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (md.level == 3'(i)) offs = cand[i];
    end
    rsv_d = !md.valid;
    if (en && md.valid) word_d = word_in - offs;
    else                word_d = word_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      rsv_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      rsv_q  <= rsv_d;
    end
  end

  assign word_out = word_q;
  assign rsv      = rsv_q;

endmodule

// File: rtl/dither_gen.sv
module dither_gen #(
  parameter int WORD_W          = 16,
  parameter int TRI_BITS        = 6,
  parameter int MIN_PERIOD_LOG2 = 11,
  parameter int FRAC_LOG2       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dith_en,
  input  logic [1:0]        rate_sel,
  input  logic [2:0]        mag_sel,
  input  logic [WORD_W-1:0] freq_word,
  output logic [WORD_W-1:0] out_word,
  output logic              rsv_flag
);
  localparam int STEP_BASE_LOG2 = MIN_PERIOD_LOG2 - 1 - TRI_BITS;

  logic              rst_meta_q, rst_sync_n;
  logic              tick;
  logic [TRI_BITS:0] tri_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  dither_rate_div #(.BASE_LOG2(STEP_BASE_LOG2)) u_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (dith_en),
    .rate_sel (rate_sel),
    .tick     (tick)
  );

  dither_tri_cnt #(.TRI_BITS(TRI_BITS)) u_tri (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (dith_en),
    .tick    (tick),
    .tri_val (tri_val)
  );

  dither_scaler #(
    .WORD_W    (WORD_W),
    .TRI_BITS  (TRI_BITS),
    .FRAC_LOG2 (FRAC_LOG2)
  ) u_scl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en       (dith_en),
    .mag_sel  (mag_sel),
    .word_in  (freq_word),
    .tri_val  (tri_val),
    .word_out (out_word),
    .rsv      (rsv_flag)
  );

endmodule

// File: rtl/dither_gen_chk.sv
module dither_gen_chk #(
  parameter int WORD_W   = 16,
  parameter int TRI_BITS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dith_en,
  input logic [2:0]        mag_sel,
  input logic [WORD_W-1:0] freq_word,
  input logic [WORD_W-1:0] out_word,
  input logic              rsv_flag,
  input logic [TRI_BITS:0] tri_val
);
  localparam int PEAK = 1 << TRI_BITS;

  logic mag_rsv;
  assign mag_rsv = (mag_sel == 3'b011) || (mag_sel == 3'b101) || (mag_sel == 3'b110);

  // R6
  a_r6_never_above: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_word <= $past(freq_word)));

  // R7
  a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !dith_en |=> (out_word == $past(freq_word)));

  // R5
  a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    mag_rsv |=> (rsv_flag && out_word == $past(freq_word)));

  // R9
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !dith_en |=> (tri_val == '0));

  // R8
  a_r8_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dith_en && tri_val != $past(tri_val)) |->
      (int'(tri_val) == int'($past(tri_val)) + 1 ||
       int'(tri_val) + 1 == int'($past(tri_val)) || tri_val == '0));

  // R8
  a_r8_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tri_val) <= PEAK);

endmodule

bind dither_gen dither_gen_chk #(.WORD_W(WORD_W), .TRI_BITS(TRI_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .dith_en   (dith_en),
  .mag_sel   (mag_sel),
  .freq_word (freq_word),
  .out_word  (out_word),
  .rsv_flag  (rsv_flag),
  .tri_val   (tri_val)
);

// File: tb/tb_dither_gen.sv
`timescale 1ns/1ps
module tb_dither_gen;
  localparam int WORD_W = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              dith_en;
  logic [1:0]        rate_sel;
  logic [2:0]        mag_sel;
  logic [WORD_W-1:0] freq_word;
  logic [WORD_W-1:0] out_word;
  logic              rsv_flag;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dither_gen dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .dith_en   (dith_en),
    .rate_sel  (rate_sel),
    .mag_sel   (mag_sel),
    .freq_word (freq_word),
    .out_word  (out_word),
    .rsv_flag  (rsv_flag)
  );

  function automatic int step_len(input int r);
    return (r == 0) ? 64 : (r == 1) ? 32 : 16;
  endfunction

  function automatic bit is_rsv(input int m);
    return (m == 3) || (m == 5) || (m == 6);
  endfunction

  function automatic int level(input int m);
    case (m)
      0: return 0;
      1: return 1;
      2: return 2;
      4: return 3;
      default: return 4;
    endcase
  endfunction

  function automatic int expect_word(input int w, input int r, input int m, input int j);
    int p, t;
    if (is_rsv(m)) return w;
    p = (j / step_len(r)) % 128;
    t = (p <= 64) ? p : 128 - p;
    return w - ((w * t) >> (14 - level(m)));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One disabled cycle (pass-through, restart), then an enabled run of n edges.
  task automatic run(input int w, input int r, input int m, input int n, input string tag);
    @(negedge clk);
    dith_en = 1'b0; freq_word = WORD_W'(w); rate_sel = 2'(r); mag_sel = 3'(m);
    @(posedge clk);
    @(negedge clk);
    check("R7 bypass", int'(out_word), w);
    check("R5 flag", int'(rsv_flag), int'(is_rsv(m)));
    dith_en = 1'b1;
    for (int j = 0; j < n; j++) begin
      @(posedge clk);
      @(negedge clk);
      check(tag, int'(out_word), expect_word(w, r, m, j));
      if (int'(out_word) > w) check("R6 above", int'(out_word), w);
      if (j == 0) check("R5 flag", int'(rsv_flag), int'(is_rsv(m)));
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dith_en = 1'b0; rate_sel = 2'b01; mag_sel = 3'b000; freq_word = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("reset out", int'(out_word), 0);
    check("reset flag", int'(rsv_flag), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Rate sweeps at full depth, slightly more than one period each
    run(16'hFFFF, 0, 7, 8200, "R1");
    run(16'hFFFF, 1, 7, 4110, "R2");
    run(16'hFFFF, 2, 7, 2060, "R3");
    run(16'hF00D, 3, 7, 2060, "R3");

    // Magnitude sweep over all eight codes
    for (int m = 0; m < 8; m++) begin
      run(16'hBEEF, 2, m, 2060, is_rsv(m) ? "R5" : "R4");
      run(16'h1234, 2, m, 600,  is_rsv(m) ? "R5" : "R4");
    end

    // Mid-sweep drop of the enable, then restart
    run(16'hC350, 1, 4, 1500, "R8");
    run(16'hC350, 1, 4, 2200, "R9");
    run(16'h0010, 0, 7, 300,  "R6");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule